// File: doc/BRIEF.md
# UART Interrupt Identification Controller

This block sits beside the register file of a 16550-style serial port and decides which of five interrupt causes the processor should service first. It holds the 4-bit interrupt enable register, the sticky line-status bits that belong to interrupt generation (overrun and break), the two transmit-empty status bits, and a separate "transmit empty pending" flag. From these, and from live status inputs supplied by the receive path and the modem-line sampler, it forms an 8-bit identification byte and a registered level interrupt.

The register decoder drives one-cycle strobes when software writes the enable register, writes the transmit holding register, reads the identification register or reads the line status register. The transmit path pulses an input when the holding area drains and another when the shifter goes idle. The FIFO storage, the shifter and the baud generator live elsewhere.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the identification byte is 0x01, the enable register is 0x0, the line status byte is 0x60 and the interrupt output is low.
- R2: A write to the enable register stores bits 3:0 of the write data (bit 0 receive data, bit 1 transmit empty, bit 2 line status, bit 3 modem status); upper bits are discarded.
- R3: The cause code is chosen by fixed priority: line status 0x6 (enabled, and any of overrun, parity, framing or break set), then character timeout 0xC (timeout flag with the receive-data enable), then received data 0x4, then transmit empty 0x2 (pending flag and its enable), then modem status 0x0 (enabled and any delta bit set).
- R4: Received data is reported only when data is ready and either the FIFO is disabled or the FIFO count is at or above the trigger level.
- R5: With no active cause the low nibble of the identification byte is 0x1; bits 7:6 are both 1 while the FIFO is enabled and both 0 otherwise; bits 5:4 are 0.
- R6: A read of the identification register while it shows code 0x2 clears the pending flag; a read showing any other code leaves it unchanged.
- R7: A write to the transmit holding register clears the pending flag and clears line status bits 5 (holding empty) and 6 (transmitter empty).
- R8: A write to the enable register that changes bit 1 sets the pending flag if the new bit 1 is 1 and holding-empty is 1, and clears it otherwise; a write that leaves bit 1 unchanged does not touch the flag.
- R9: A read of the line status register clears overrun (bit 1) and break (bit 4); parity (bit 2) and framing (bit 3) follow their inputs; bit 0 follows data-ready; a new overrun or break event in the same cycle as the read wins.
- R10: A transmit FIFO reset sets holding-empty and sets the pending flag.
- R11: A drain pulse from the transmit path sets holding-empty and the pending flag; an idle pulse sets transmitter-empty.
- R12: The identification byte and the interrupt output are registered: both reflect the state of the previous cycle, and the interrupt is high exactly when that code is not 0x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wdata_i | input | 8 | Register write data |
| ier_wr_i | input | 1 | Enable register write strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| iir_rd_i | input | 1 | Identification register read strobe |
| lsr_rd_i | input | 1 | Line status register read strobe |
| fifo_en_i | input | 1 | FIFO mode enabled |
| txf_rst_i | input | 1 | Transmit FIFO reset pulse |
| thr_empty_i | input | 1 | Holding area drained pulse |
| tx_done_i | input | 1 | Shifter idle pulse |
| rx_ready_i | input | 1 | Receive data ready |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| rx_trig_i | input | CNT_W | Receive trigger level |
| timeout_i | input | 1 | Character timeout flag |
| ovr_set_i | input | 1 | Overrun event pulse |
| brk_set_i | input | 1 | Break event pulse |
| par_err_i | input | 1 | Parity error level |
| frm_err_i | input | 1 | Framing error level |
| msr_delta_i | input | 4 | Modem status delta bits |
| ier_o | output | 4 | Enable register |
| lsr_o | output | 8 | Line status byte |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench chases the pending-flag corner cases: reading the identification register while a higher-priority cause hides the transmit code must leave the flag alive, so a design that cleared it on any read would lose the transmit interrupt once the line error is serviced. Enable writes that rewrite bit 1 with the same value must not re-arm the flag, and a design that re-armed on every write would raise spurious transmit interrupts. The trigger-level boundary (count one below, equal to the level) and the FIFO-disabled bypass are probed, as is a line-status read that must keep parity and framing while dropping overrun and break. Long stretches of random strobes are then compared against the behavioural model every cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    IID_MODEM   = 4'h0,
    IID_NONE    = 4'h1,
    IID_THRE    = 4'h2,
    IID_RXDATA  = 4'h4,
    IID_LINE    = 4'h6,
    IID_TIMEOUT = 4'hC
  } iid_e;

  localparam int NUM_SRC = 5;

  // enable register bit positions
  localparam int IEN_RX    = 0;
  localparam int IEN_TX    = 1;
  localparam int IEN_LINE  = 2;
  localparam int IEN_MODEM = 3;

  // line status bit positions
  localparam int LS_DR   = 0;
  localparam int LS_OVR  = 1;
  localparam int LS_PAR  = 2;
  localparam int LS_FRM  = 3;
  localparam int LS_BRK  = 4;
  localparam int LS_THRE = 5;
  localparam int LS_TEMT = 6;

endpackage

// File: rtl/uart_lsr_track.sv
module uart_lsr_track
  import uart_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       thr_wr_i,
  input  logic       txf_rst_i,
  input  logic       thr_empty_i,
  input  logic       tx_done_i,
  input  logic       lsr_rd_i,
  input  logic       ovr_set_i,
  input  logic       brk_set_i,
  input  logic       par_err_i,
  input  logic       frm_err_i,
  input  logic       rx_ready_i,
  output logic [7:0] lsr_o,
  output logic       err_any_o
);

  logic ovr_q, brk_q, thre_q, temt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q  <= 1'b0;
      brk_q  <= 1'b0;
      thre_q <= 1'b1;
      temt_q <= 1'b1;
    end else begin
      // new event beats the read-clear
      ovr_q <= ovr_set_i | (ovr_q & ~lsr_rd_i);
      brk_q <= brk_set_i | (brk_q & ~lsr_rd_i);

      if (txf_rst_i)        thre_q <= 1'b1;
      else if (thr_wr_i)    thre_q <= 1'b0;
      else if (thr_empty_i) thre_q <= 1'b1;

      if (thr_wr_i)         temt_q <= 1'b0;
      else if (tx_done_i)   temt_q <= 1'b1;
    end
  end

  always_comb begin
    lsr_o          = '0;
    lsr_o[LS_DR]   = rx_ready_i;
    lsr_o[LS_OVR]  = ovr_q;
    lsr_o[LS_PAR]  = par_err_i;
    lsr_o[LS_FRM]  = frm_err_i;
    lsr_o[LS_BRK]  = brk_q;
    lsr_o[LS_THRE] = thre_q;
    lsr_o[LS_TEMT] = temt_q;
  end

  assign err_any_o = ovr_q | brk_q | par_err_i | frm_err_i;

endmodule

// File: rtl/uart_thre_pend.sv
module uart_thre_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txf_rst_i,
  input  logic thr_wr_i,
  input  logic ier_wr_i,
  input  logic ien_tx_old_i,
  input  logic ien_tx_new_i,
  input  logic thre_i,
  input  logic thr_empty_i,
  input  logic iir_rd_i,
  input  logic iir_shows_tx_i,
  output logic pend_o
);

  logic pend_q;
  logic ien_tx_flip;

  assign ien_tx_flip = ier_wr_i & (ien_tx_old_i ^ ien_tx_new_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        pend_q <= 1'b0;
    else if (txf_rst_i)                 pend_q <= 1'b1;
    else if (thr_wr_i)                  pend_q <= 1'b0;
    else if (ien_tx_flip)               pend_q <= ien_tx_new_i & thre_i;
    else if (thr_empty_i)               pend_q <= 1'b1;
    else if (iir_rd_i & iir_shows_tx_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [3:0]       ien_i,
  input  logic             err_any_i,
  input  logic             timeout_i,
  input  logic             rx_ready_i,
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic             pend_i,
  input  logic [3:0]       msr_delta_i,
  output iid_e             code_o
);

  // index 0 is highest priority
  logic [NUM_SRC-1:0] req;
  iid_e               src_code [NUM_SRC];
  logic               rx_level_ok;

  assign rx_level_ok = ~fifo_en_i | (rx_count_i >= rx_trig_i);

  assign req[0] = ien_i[IEN_LINE]  & err_any_i;
  assign req[1] = ien_i[IEN_RX]    & timeout_i;
  assign req[2] = ien_i[IEN_RX]    & rx_ready_i & rx_level_ok;
  assign req[3] = ien_i[IEN_TX]    & pend_i;
  assign req[4] = ien_i[IEN_MODEM] & (|msr_delta_i);

  assign src_code[0] = IID_LINE;
  assign src_code[1] = IID_TIMEOUT;
  assign src_code[2] = IID_RXDATA;
  assign src_code[3] = IID_THRE;
  assign src_code[4] = IID_MODEM;

  always_comb begin
    code_o = IID_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) code_o = src_code[i];
    end
  end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       wdata_i,
  input  logic             ier_wr_i,
  input  logic             thr_wr_i,
  input  logic             iir_rd_i,
  input  logic             lsr_rd_i,
  input  logic             fifo_en_i,
  input  logic             txf_rst_i,
  input  logic             thr_empty_i,
  input  logic             tx_done_i,
  input  logic             rx_ready_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic             timeout_i,
  input  logic             ovr_set_i,
  input  logic             brk_set_i,
  input  logic             par_err_i,
  input  logic             frm_err_i,
  input  logic [3:0]       msr_delta_i,
  output logic [3:0]       ier_o,
  output logic [7:0]       lsr_o,
  output logic [7:0]       iir_o,
  output logic             irq_o
);

  localparam logic [7:0] IIR_RST = {4'h0, IID_NONE};

  logic [3:0] ien_q;
  logic [7:0] iir_q;
  logic       irq_q;
  logic [7:0] lsr;
  logic       err_any;
  logic       pend;
  iid_e       code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ien_q <= '0;
    else if (ier_wr_i) ien_q <= wdata_i[3:0];
  end

  uart_lsr_track u_lsr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .thr_wr_i    (thr_wr_i),
    .txf_rst_i   (txf_rst_i),
    .thr_empty_i (thr_empty_i),
    .tx_done_i   (tx_done_i),
    .lsr_rd_i    (lsr_rd_i),
    .ovr_set_i   (ovr_set_i),
    .brk_set_i   (brk_set_i),
    .par_err_i   (par_err_i),
    .frm_err_i   (frm_err_i),
    .rx_ready_i  (rx_ready_i),
    .lsr_o       (lsr),
    .err_any_o   (err_any)
  );

  uart_thre_pend u_pend (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .txf_rst_i      (txf_rst_i),
    .thr_wr_i       (thr_wr_i),
    .ier_wr_i       (ier_wr_i),
    .ien_tx_old_i   (ien_q[IEN_TX]),
    .ien_tx_new_i   (wdata_i[IEN_TX]),
    .thre_i         (lsr[LS_THRE]),
    .thr_empty_i    (thr_empty_i),
    .iir_rd_i       (iir_rd_i),
    .iir_shows_tx_i (iir_q[3:0] == IID_THRE),
    .pend_o         (pend)
  );

  uart_irq_prio #(.CNT_W(CNT_W)) u_prio (
    .ien_i       (ien_q),
    .err_any_i   (err_any),
    .timeout_i   (timeout_i),
    .rx_ready_i  (rx_ready_i),
    .fifo_en_i   (fifo_en_i),
    .rx_count_i  (rx_count_i),
    .rx_trig_i   (rx_trig_i),
    .pend_i      (pend),
    .msr_delta_i (msr_delta_i),
    .code_o      (code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iir_q <= IIR_RST;
      irq_q <= 1'b0;
    end else begin
      iir_q <= {fifo_en_i, fifo_en_i, 2'b00, code};
      irq_q <= (code != IID_NONE);
    end
  end

  assign ier_o = ien_q;
  assign lsr_o = lsr;
  assign iir_o = iir_q;
  assign irq_o = irq_q;

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] wdata_i,
  input logic       ier_wr_i,
  input logic       thr_wr_i,
  input logic       lsr_rd_i,
  input logic       fifo_en_i,
  input logic       txf_rst_i,
  input logic       thr_empty_i,
  input logic       tx_done_i,
  input logic       ovr_set_i,
  input logic       brk_set_i,
  input logic [3:0] ier_o,
  input logic [7:0] lsr_o,
  input logic [7:0] iir_o,
  input logic       irq_o
);

  assert_ier_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_wr_i |=> ier_o == $past(wdata_i[3:0]));

  assert_code_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_o[3:0] inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h6, 4'hC});

  assert_hdr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_o[7:6] == {2{$past(fifo_en_i)}} && iir_o[5:4] == 2'b00);

  assert_thr_wr_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_wr_i && !txf_rst_i) |=> (!lsr_o[5] && !lsr_o[6]));

  assert_lsr_rd_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !ovr_set_i && !brk_set_i) |=> (!lsr_o[1] && !lsr_o[4]));

  assert_txf_rst_sets_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txf_rst_i |=> lsr_o[5]);

  assert_drain_sets_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_empty_i && !thr_wr_i) |=> lsr_o[5]);

  assert_idle_sets_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && !thr_wr_i) |=> lsr_o[6]);

  assert_irq_level_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (iir_o[3:0] != 4'h1));

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wdata_i     (wdata_i),
  .ier_wr_i    (ier_wr_i),
  .thr_wr_i    (thr_wr_i),
  .lsr_rd_i    (lsr_rd_i),
  .fifo_en_i   (fifo_en_i),
  .txf_rst_i   (txf_rst_i),
  .thr_empty_i (thr_empty_i),
  .tx_done_i   (tx_done_i),
  .ovr_set_i   (ovr_set_i),
  .brk_set_i   (brk_set_i),
  .ier_o       (ier_o),
  .lsr_o       (lsr_o),
  .iir_o       (iir_o),
  .irq_o       (irq_o)
);

// File: tb/uart_irq_ctrl_tb_top.sv
module uart_irq_ctrl_tb_top;

  localparam int CNT_W = 5;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [7:0]       wdata_i = '0;
  logic             ier_wr_i = 0, thr_wr_i = 0, iir_rd_i = 0, lsr_rd_i = 0;
  logic             fifo_en_i = 0, txf_rst_i = 0, thr_empty_i = 0, tx_done_i = 0;
  logic             rx_ready_i = 0;
  logic [CNT_W-1:0] rx_count_i = '0;
  logic [CNT_W-1:0] rx_trig_i = 5'd1;
  logic             timeout_i = 0, ovr_set_i = 0, brk_set_i = 0;
  logic             par_err_i = 0, frm_err_i = 0;
  logic [3:0]       msr_delta_i = '0;
  logic [3:0]       ier_o;
  logic [7:0]       lsr_o, iir_o;
  logic             irq_o;

  always #5 clk_i = ~clk_i;

  uart_irq_ctrl #(.CNT_W(CNT_W)) dut_i (.*);

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [3:0] m_ier;
  logic [7:0] m_iir;
  logic       m_irq, m_ovr, m_brk, m_thre, m_temt, m_pend;

  function automatic logic [3:0] pick_code();
    if (m_ier[2] && (m_ovr || m_brk || par_err_i || frm_err_i)) return 4'h6;
    if (m_ier[0] && timeout_i) return 4'hC;
    if (m_ier[0] && rx_ready_i && (!fifo_en_i || rx_count_i >= rx_trig_i)) return 4'h4;
    if (m_ier[1] && m_pend) return 4'h2;
    if (m_ier[3] && (msr_delta_i != 0)) return 4'h0;
    return 4'h1;
  endfunction

  task automatic model_reset();
    m_ier = 0; m_iir = 8'h01; m_irq = 0;
    m_ovr = 0; m_brk = 0; m_thre = 1; m_temt = 1; m_pend = 0;
  endtask

  task automatic model_edge();
    logic [3:0] c;
    logic       p, th, te;
    c  = pick_code();
    p  = m_pend;
    th = m_thre;
    te = m_temt;
    if (txf_rst_i) p = 1;
    else if (thr_wr_i) p = 0;
    else if (ier_wr_i && (wdata_i[1] != m_ier[1])) p = wdata_i[1] & m_thre;
    else if (thr_empty_i) p = 1;
    else if (iir_rd_i && m_iir[3:0] == 4'h2) p = 0;
    if (txf_rst_i) th = 1; else if (thr_wr_i) th = 0; else if (thr_empty_i) th = 1;
    if (thr_wr_i) te = 0; else if (tx_done_i) te = 1;
    m_ovr  = ovr_set_i | (m_ovr & ~lsr_rd_i);
    m_brk  = brk_set_i | (m_brk & ~lsr_rd_i);
    m_pend = p; m_thre = th; m_temt = te;
    if (ier_wr_i) m_ier = wdata_i[3:0];
    m_iir = {fifo_en_i, fifo_en_i, 2'b00, c};
    m_irq = (c != 4'h1);
  endtask

  task automatic check8(string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h (t=%0t)", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [7:0] e_lsr;
    e_lsr = {1'b0, m_temt, m_thre, m_brk, frm_err_i, par_err_i, m_ovr, rx_ready_i};
    check8("iir", iir_o, m_iir);
    check8("irq", {7'd0, irq_o}, {7'd0, m_irq});
    check8("ier", {4'd0, ier_o}, {4'd0, m_ier});
    check8("lsr", lsr_o, e_lsr);
  endtask

  task automatic tick();
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    compare();
    ier_wr_i = 0; thr_wr_i = 0; iir_rd_i = 0; lsr_rd_i = 0;
    txf_rst_i = 0; thr_empty_i = 0; tx_done_i = 0; ovr_set_i = 0; brk_set_i = 0;
  endtask

  task automatic wr_ier(logic [7:0] d);
    wdata_i = d; ier_wr_i = 1; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    // R1: reset values before first active edge
    cur_req = "R1";
    compare();
    check8("iir reset", iir_o, 8'h01);
    check8("lsr reset", lsr_o, 8'h60);
    rst_ni = 1;
    tick(); tick();

    // R2: only low nibble kept
    cur_req = "R2";
    wr_ier(8'hF0);
    check8("ier upper dropped", {4'd0, ier_o}, 8'h00);
    wr_ier(8'h0D);

    // R8: bit1 0->1 with holding empty arms the flag
    cur_req = "R8";
    wr_ier(8'h0F);
    tick();
    check8("tx code after arm", iir_o, 8'h02);
    // rewrite with bit1 still 1 changes nothing
    wr_ier(8'h0F); tick();
    // R6: read while showing 0x2 clears
    cur_req = "R6";
    iir_rd_i = 1; tick(); tick();
    check8("after read", iir_o, 8'h01);
    // R8: rewriting bit1 unchanged must not re-arm
    cur_req = "R8";
    wr_ier(8'h0F); tick();
    check8("no re-arm", iir_o, 8'h01);
    // toggle off then on re-arms
    wr_ier(8'h0D); wr_ier(8'h0F); tick();
    check8("re-armed", iir_o, 8'h02);

    // R6: hidden by line error, read must not clear the flag
    cur_req = "R6";
    par_err_i = 1; tick(); tick();
    check8("line wins", iir_o, 8'h06);
    iir_rd_i = 1; tick();
    par_err_i = 0; tick(); tick();
    check8("flag survived", iir_o, 8'h02);

    // R7 / R11
    cur_req = "R7";
    thr_wr_i = 1; tick(); tick();
    check8("thr write", lsr_o, 8'h00);
    cur_req = "R11";
    thr_empty_i = 1; tick();
    tx_done_i = 1; tick(); tick();
    check8("drain and idle", lsr_o, 8'h60);

    // R3 priority stack
    cur_req = "R3";
    msr_delta_i = 4'h2; iir_rd_i = 1; tick(); tick();
    check8("modem", iir_o, 8'h00);
    rx_ready_i = 1; tick(); tick();
    check8("rx over modem", iir_o, 8'h04);
    timeout_i = 1; tick(); tick();
    check8("timeout over rx", iir_o, 8'h0C);
    brk_set_i = 1; tick(); tick();
    check8("break over timeout", iir_o, 8'h06);
    // R9: read clears break, overrun set in same cycle wins
    cur_req = "R9";
    lsr_rd_i = 1; ovr_set_i = 1; frm_err_i = 1; tick();
    lsr_rd_i = 1; tick();
    frm_err_i = 0; tick();
    timeout_i = 0; msr_delta_i = 0; tick();

    // R4: trigger level boundary
    cur_req = "R4";
    fifo_en_i = 1; rx_trig_i = 5'd8; rx_count_i = 5'd7; tick(); tick();
    check8("below trig", iir_o, 8'hC1);
    rx_count_i = 5'd8; tick(); tick();
    check8("at trig", iir_o, 8'hC4);
    wr_ier(8'h0E); tick();
    check8("rx disabled", iir_o, 8'hC1);
    wr_ier(8'h0F);
    fifo_en_i = 0; rx_count_i = 0; tick(); tick();
    check8("fifo off bypass", iir_o, 8'h04);
    rx_ready_i = 0;

    // R5 header
    cur_req = "R5";
    fifo_en_i = 1; tick(); tick();
    fifo_en_i = 0; tick(); tick();
    check8("no fifo idle", iir_o, 8'h01);

    // R10
    cur_req = "R10";
    thr_wr_i = 1; tick();
    txf_rst_i = 1; tick(); tick();
    check8("tx code after fifo reset", iir_o, 8'h02);

    // R12 and everything else: random traffic against the model
    cur_req = "R12";
    for (int i = 0; i < 3000; i++) begin
      wdata_i     = 8'($urandom);
      ier_wr_i    = ($urandom % 8) == 0;
      thr_wr_i    = ($urandom % 10) == 0;
      iir_rd_i    = ($urandom % 5) == 0;
      lsr_rd_i    = ($urandom % 7) == 0;
      txf_rst_i   = ($urandom % 40) == 0;
      thr_empty_i = ($urandom % 9) == 0;
      tx_done_i   = ($urandom % 9) == 0;
      ovr_set_i   = ($urandom % 30) == 0;
      brk_set_i   = ($urandom % 30) == 0;
      if (($urandom % 16) == 0) fifo_en_i = ~fifo_en_i;
      if (($urandom % 6) == 0) rx_ready_i = ~rx_ready_i;
      if (($urandom % 6) == 0) rx_count_i = 5'($urandom % 17);
      if (($urandom % 20) == 0) rx_trig_i = 5'(($urandom % 2) ? 4 : 14);
      if (($urandom % 12) == 0) timeout_i = ~timeout_i;
      if (($urandom % 25) == 0) par_err_i = ~par_err_i;
      if (($urandom % 25) == 0) frm_err_i = ~frm_err_i;
      if (($urandom % 10) == 0) msr_delta_i = 4'($urandom);
      tick();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule